// File: doc/BRIEF.md
# Byte Field and Shift Unit

A purely combinational 64-bit datapath slice that performs shifts and byte-granular field handling for an integer execute stage. Software builds unaligned loads and stores, and partial-word stores, out of these operations. It clears a field of bytes (masking), pulls a field out to the bottom of a word (extraction), moves a low field to a byte position (insertion), and removes bytes chosen by an 8-bit select (zeroing). Each of masking, extraction and insertion has a low form and a high form. The low form handles the part of a field that starts at a byte offset. The high form handles the part that spills past bit 63 into the next quadword.

Operand A is the data word. Operand B is either a register value or a literal: its low three bits give a byte offset, and its low six bits give a shift amount. A 7-bit function code selects the operation. The unit holds no state and has no flow control. The result follows the inputs within the same cycle and is registered by the surrounding pipeline.

For every masking, extraction and insertion code, bits 5:4 of the function code give the field size: 00 byte (8 bits), 01 word (16), 10 longword (32), 11 quad (64). The offset below is B[2:0], and "8·off" is that offset in bits.

Top module: `byte_shift_unit`

## Requirements
- R1: Code 0x39 shifts A left and code 0x34 shifts A right with zero fill, both by B[5:0]. B[63:6] has no effect on the result.
- R2: Code 0x3c shifts A right by B[5:0] and fills the vacated bits with copies of A[63]. Any shift by 0 returns A unchanged.
- R3: For masking, extraction and insertion, only B[2:0] matters. B[63:3] has no effect on the result.
- R4: Low masking (0x02, 0x12, 0x22, 0x32) returns A with the bits of a field-sized block of ones, moved up by 8·off, cleared. Ones that pass bit 63 are lost.
- R5: High masking (0x52, 0x62, 0x72) returns A with the ones of the field block, moved down by 64−8·off, cleared. An offset of 0 returns A unchanged.
- R6: Low extraction (0x06, 0x16, 0x26, 0x36) moves A right by 8·off with zero fill. It then keeps only the low field-size bits and zeroes the rest.
- R7: High extraction (0x5a, 0x6a, 0x7a) moves A left by (64−8·off) mod 64 and keeps the low field-size bits. An offset of 0 therefore yields A's low field unshifted.
- R8: Low insertion (0x0b, 0x1b, 0x2b, 0x3b) takes the low field-size bits of A and moves them left by 8·off. Bits past bit 63 are lost.
- R9: High insertion (0x57, 0x67, 0x77) takes the low field-size bits of A and moves them right by 64−8·off. An offset of 0 gives zero.
- R10: Code 0x30 zeroes byte i of A whenever B[i] is 1. Code 0x31 zeroes byte i whenever B[i] is 0. B[63:8] has no effect.
- R11: Any function code not listed in R1 to R10 gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | Data operand |
| opnd_b | input | 64 | Offset, shift amount or byte-select operand |
| func_code | input | 7 | Operation select |
| result | output | 64 | Operation result |

## Verification
The hardest cases are the high forms at offset 0. Here the nominal move distance of 64 wraps to 0, and each code has its own rule: masking passes A through, insertion gives zero, and extraction gives an unshifted field. These cases only appear when B's low three bits are all zero. The stimulus therefore sweeps every offset from 0 to 7 for each of the 21 field codes, with several data patterns. During that sweep, B's upper bits carry a nonzero pattern, so a stray use of those bits shows up. All 256 byte selects are applied to both zeroing codes.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int unsigned BSU_DW    = 64;
  localparam int unsigned BSU_NB    = BSU_DW / 8;
  localparam int unsigned BSU_OFFW  = $clog2(BSU_NB);
  localparam int unsigned BSU_SHW   = $clog2(BSU_DW);
  localparam int unsigned BSU_FW    = 7;

  typedef enum logic [1:0] {
    FLD_BYTE = 2'd0,
    FLD_WORD = 2'd1,
    FLD_LONG = 2'd2,
    FLD_QUAD = 2'd3
  } fld_size_e;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_SHIFT = 3'd1,
    CLS_MASK  = 3'd2,
    CLS_EXT   = 3'd3,
    CLS_INS   = 3'd4,
    CLS_ZAP   = 3'd5
  } op_class_e;

  typedef enum logic [1:0] {
    SHK_LEFT  = 2'd0,
    SHK_RIGHT = 2'd1,
    SHK_ARITH = 2'd2
  } shift_kind_e;

  typedef struct packed {
    op_class_e   cls;
    logic        high;
    fld_size_e   size;
    shift_kind_e shk;
    logic        zap_inv;
  } op_dec_t;

  // Block of ones as wide as the selected field
  function automatic logic [BSU_DW-1:0] fld_ones(fld_size_e s);
    logic [BSU_DW-1:0] r;
    unique case (s)
      FLD_BYTE: r = BSU_DW'({8{1'b1}});
      FLD_WORD: r = BSU_DW'({16{1'b1}});
      FLD_LONG: r = BSU_DW'({32{1'b1}});
      default:  r = {BSU_DW{1'b1}};
    endcase
    return r;
  endfunction

  function automatic op_dec_t decode_func(logic [BSU_FW-1:0] f);
    op_dec_t d;
    d.cls     = CLS_NONE;
    d.high    = f[6];
    d.size    = fld_size_e'(f[5:4]);
    d.shk     = SHK_LEFT;
    d.zap_inv = f[0];
    case (f)
      7'h39: begin d.cls = CLS_SHIFT; d.shk = SHK_LEFT;  end
      7'h34: begin d.cls = CLS_SHIFT; d.shk = SHK_RIGHT; end
      7'h3c: begin d.cls = CLS_SHIFT; d.shk = SHK_ARITH; end
      7'h02, 7'h12, 7'h22, 7'h32,
      7'h52, 7'h62, 7'h72:        d.cls = CLS_MASK;
      7'h06, 7'h16, 7'h26, 7'h36,
      7'h5a, 7'h6a, 7'h7a:        d.cls = CLS_EXT;
      7'h0b, 7'h1b, 7'h2b, 7'h3b,
      7'h57, 7'h67, 7'h77:        d.cls = CLS_INS;
      7'h30, 7'h31:               d.cls = CLS_ZAP;
      default:                    d.cls = CLS_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bsu_shifter.sv
module bsu_shifter
  import bsu_pkg::*;
(
  input  logic [BSU_DW-1:0]  a,
  input  logic [BSU_SHW-1:0] amt,
  input  shift_kind_e        kind,
  output logic [BSU_DW-1:0]  y
);

  always_comb begin
    unique case (kind)
      SHK_RIGHT: y = a >> amt;
      SHK_ARITH: y = BSU_DW'($signed(a) >>> amt);
      default:   y = a << amt;
    endcase
  end

  // R2: arithmetic shift never changes the sign bit
  always_comb begin
    if (kind == SHK_ARITH) begin
      a_r2_sign_kept: assert (y[BSU_DW-1] == a[BSU_DW-1])
        else $error("arithmetic shift lost sign");
    end
  end

  // R2: zero distance is identity for every kind
  always_comb begin
    if (amt == '0) begin
      a_r2_zero_identity: assert (y == a)
        else $error("zero shift altered operand");
    end
  end

endmodule

// File: rtl/bsu_byte_mask.sv
module bsu_byte_mask
  import bsu_pkg::*;
(
  input  logic [BSU_DW-1:0]   a,
  input  logic [BSU_NB-1:0]   bsel,
  input  logic [BSU_OFFW-1:0] off,
  input  fld_size_e           size,
  input  logic                high,
  output logic [BSU_DW-1:0]   msk_y,
  output logic [BSU_DW-1:0]   zap_y,
  output logic [BSU_DW-1:0]   zapn_y
);

  logic [BSU_DW-1:0]  ones;
  logic [BSU_SHW-1:0] up_sh;
  logic [BSU_SHW-1:0] dn_sh;
  logic [BSU_DW-1:0]  lo_clr;
  logic [BSU_DW-1:0]  hi_clr;

  assign ones   = fld_ones(size);
  assign up_sh  = {off, 3'b000};
  assign dn_sh  = BSU_SHW'(0) - up_sh;
  assign lo_clr = ones << up_sh;
  assign hi_clr = ones >> dn_sh;

  always_comb begin
    if (!high)           msk_y = a & ~lo_clr;
    else if (off == '0)  msk_y = a;
    else                 msk_y = a & ~hi_clr;
  end

  for (genvar gi = 0; gi < BSU_NB; gi++) begin : g_lane
    assign zap_y[8*gi +: 8]  = bsel[gi] ? 8'h00 : a[8*gi +: 8];
    assign zapn_y[8*gi +: 8] = bsel[gi] ? a[8*gi +: 8] : 8'h00;
  end

  // R4/R5: masking only ever clears bits of A
  always_comb begin
    a_r4_mask_subset: assert ((msk_y & ~a) == '0)
      else $error("mask set a bit not present in A");
  end

  // R10: the two zeroing forms split A into disjoint halves
  always_comb begin
    a_r10_zap_partition: assert (((zap_y & zapn_y) == '0) && ((zap_y | zapn_y) == a))
      else $error("zap forms do not partition A");
  end

endmodule

// File: rtl/bsu_byte_field.sv
module bsu_byte_field
  import bsu_pkg::*;
(
  input  logic [BSU_DW-1:0]   a,
  input  logic [BSU_OFFW-1:0] off,
  input  fld_size_e           size,
  input  logic                high,
  input  logic                ins,
  output logic [BSU_DW-1:0]   y
);

  logic [BSU_DW-1:0]  ones;
  logic [BSU_DW-1:0]  low_fld;
  logic [BSU_SHW-1:0] up_sh;
  logic [BSU_SHW-1:0] dn_sh;
  logic [BSU_DW-1:0]  ext_y;
  logic [BSU_DW-1:0]  ins_y;

  assign ones    = fld_ones(size);
  assign low_fld = a & ones;
  assign up_sh   = {off, 3'b000};
  assign dn_sh   = BSU_SHW'(0) - up_sh;

  always_comb begin
    if (high) ext_y = (a << dn_sh) & ones;
    else      ext_y = (a >> up_sh) & ones;
  end

  always_comb begin
    if (!high)          ins_y = low_fld << up_sh;
    else if (off == '0) ins_y = '0;
    else                ins_y = low_fld >> dn_sh;
  end

  assign y = ins ? ins_y : ext_y;

  // R6/R7: an extracted field never reaches above its size
  always_comb begin
    if (!ins) begin
      a_r6_ext_width: assert ((y & ~ones) == '0)
        else $error("extract wider than field");
    end
  end

  // R8/R9: insertion only moves bits, it never creates them
  always_comb begin
    if (ins) begin
      a_r8_ins_no_growth: assert ($countones(y) <= $countones(a))
        else $error("insert created bits");
    end
  end

endmodule

// File: rtl/byte_shift_unit.sv
module byte_shift_unit
  import bsu_pkg::*;
(
  input  logic [BSU_DW-1:0] opnd_a,
  input  logic [BSU_DW-1:0] opnd_b,
  input  logic [BSU_FW-1:0] func_code,
  output logic [BSU_DW-1:0] result
);

  op_dec_t           dec;
  logic [BSU_DW-1:0] sh_y;
  logic [BSU_DW-1:0] msk_y;
  logic [BSU_DW-1:0] zap_y;
  logic [BSU_DW-1:0] zapn_y;
  logic [BSU_DW-1:0] fld_y;
  logic              unused_b_hi;

  assign dec         = decode_func(func_code);
  assign unused_b_hi = ^opnd_b[BSU_DW-1:BSU_SHW];

  bsu_shifter u_shift (
    .a    (opnd_a),
    .amt  (opnd_b[BSU_SHW-1:0]),
    .kind (dec.shk),
    .y    (sh_y)
  );

  bsu_byte_mask u_mask (
    .a      (opnd_a),
    .bsel   (opnd_b[BSU_NB-1:0]),
    .off    (opnd_b[BSU_OFFW-1:0]),
    .size   (dec.size),
    .high   (dec.high),
    .msk_y  (msk_y),
    .zap_y  (zap_y),
    .zapn_y (zapn_y)
  );

  bsu_byte_field u_field (
    .a    (opnd_a),
    .off  (opnd_b[BSU_OFFW-1:0]),
    .size (dec.size),
    .high (dec.high),
    .ins  (dec.cls == CLS_INS),
    .y    (fld_y)
  );

  always_comb begin
    unique case (dec.cls)
      CLS_SHIFT:        result = sh_y;
      CLS_MASK:         result = msk_y;
      CLS_EXT, CLS_INS: result = fld_y;
      CLS_ZAP:          result = dec.zap_inv ? zapn_y : zap_y;
      default:          result = '0;
    endcase
  end

  // R11: unlisted codes produce nothing
  always_comb begin
    if (dec.cls == CLS_NONE) begin
      a_r11_unknown_zero: assert (result == '0)
        else $error("unlisted code produced data");
    end
  end

endmodule

// File: tb/byte_shift_unit_tb_top.sv
`timescale 1ns/1ps
module byte_shift_unit_tb_top;

  logic        clk = 1'b0;
  logic [63:0] a_in;
  logic [63:0] b_in;
  logic [6:0]  f_in;
  logic [63:0] res;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  byte_shift_unit dut_i (
    .opnd_a    (a_in),
    .opnd_b    (b_in),
    .func_code (f_in),
    .result    (res)
  );

  localparam logic [6:0] MASK_CODES [7] = '{7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72};
  localparam logic [6:0] EXT_CODES  [7] = '{7'h06, 7'h16, 7'h26, 7'h36, 7'h5a, 7'h6a, 7'h7a};
  localparam logic [6:0] INS_CODES  [7] = '{7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h57, 7'h67, 7'h77};
  localparam logic [63:0] PATS [3] = '{64'h0123_4567_89ab_cdef,
                                      64'hfedc_ba98_7654_3210,
                                      64'h8000_ffff_0000_7f01};

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [6:0] f);
    @(posedge clk);
    #1;
    a_in = a; b_in = b; f_in = f;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: f=%h a=%h b=%h actual=%h expected=%h", req, f_in, a_in, b_in, got, exp);
    end
  endtask

  // Byte-wise reference: kind 0 mask, 1 extract, 2 insert
  function automatic logic [63:0] ref_field(int kind, bit high, int n, logic [63:0] a, int off);
    logic [63:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      int s;
      logic [7:0] v = 8'h00;
      case (kind)
        0: begin
          if (!high) v = (j >= off && j < off + n) ? 8'h00 : a[8*j +: 8];
          else       v = (j < off + n - 8) ? 8'h00 : a[8*j +: 8];
        end
        1: begin
          if (!high) s = j + off;
          else       s = (off == 0) ? j : j + off - 8;
          if (j < n && s >= 0 && s < 8) v = a[8*s +: 8];
        end
        default: begin
          if (!high) s = j - off;
          else       s = (off == 0) ? -1 : j + 8 - off;
          if (s >= 0 && s < n) v = a[8*s +: 8];
        end
      endcase
      r[8*j +: 8] = v;
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_shift(int kind, logic [63:0] a, int s);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (kind == 0)      r[i] = (i >= s) ? a[i-s] : 1'b0;
      else if (kind == 1) r[i] = (i + s < 64) ? a[i+s] : 1'b0;
      else                r[i] = (i + s < 64) ? a[i+s] : a[63];
    end
    return r;
  endfunction

  task automatic t_idle;
    // R11: code 0 with zero operands gives zero
    drive(64'h0, 64'h0, 7'h00);
    check("R11 idle", res, 64'h0);
  endtask

  task automatic t_shifts;
    for (int s = 0; s < 64; s++) begin
      for (int p = 0; p < 3; p++) begin
        logic [63:0] b = {58'h2aa_5555_1234_abcd, 6'(s)};
        drive(PATS[p], b, 7'h39);
        check("R1 sll", res, ref_shift(0, PATS[p], s));
        drive(PATS[p], b, 7'h34);
        check("R1 srl", res, ref_shift(1, PATS[p], s));
        drive(PATS[p], b, 7'h3c);
        check("R2 sra", res, ref_shift(2, PATS[p], s));
      end
    end
    drive(64'h8000_0000_0000_0000, 64'd63, 7'h3c);
    check("R2 sra full", res, 64'hffff_ffff_ffff_ffff);
  endtask

  task automatic t_field(input int kind, input string req_lo, input string req_hi);
    for (int ci = 0; ci < 7; ci++) begin
      logic [6:0] code = (kind == 0) ? MASK_CODES[ci] : (kind == 1) ? EXT_CODES[ci] : INS_CODES[ci];
      int n = 1 << code[5:4];
      for (int off = 0; off < 8; off++) begin
        for (int p = 0; p < 3; p++) begin
          // R3: upper B bits carry junk throughout
          logic [63:0] b = {61'h1f3c_5a69_0ff0_a5c3, 3'(off)};
          drive(PATS[p], b, code);
          check(code[6] ? req_hi : req_lo, res, ref_field(kind, code[6], n, PATS[p], off));
        end
      end
    end
  endtask

  task automatic t_offset_zero_edges;
    drive(64'hffff_ffff_ffff_ffff, 64'h0, 7'h72);
    check("R5 mask-high off0 passthru", res, 64'hffff_ffff_ffff_ffff);
    drive(64'hffff_ffff_ffff_ffff, 64'h0, 7'h77);
    check("R9 ins-high off0 zero", res, 64'h0);
    drive(64'h1122_3344_5566_7788, 64'h0, 7'h5a);
    check("R7 ext-high off0", res, 64'h0000_0000_0000_7788);
    drive(64'hffff_ffff_ffff_ffff, 64'h7, 7'h32);
    check("R4 mask-low quad off7", res, 64'h00ff_ffff_ffff_ffff);
    drive(64'h1122_3344_5566_7788, 64'hffff_ffff_ffff_fff8, 7'h0b);
    check("R3 upper B ignored ins-low", res, 64'h0000_0000_0000_0088);
  endtask

  task automatic t_zap;
    for (int m = 0; m < 256; m++) begin
      logic [63:0] exp_z;
      logic [63:0] exp_n;
      for (int j = 0; j < 8; j++) begin
        exp_z[8*j +: 8] = m[j] ? 8'h00 : PATS[0][8*j +: 8];
        exp_n[8*j +: 8] = m[j] ? PATS[0][8*j +: 8] : 8'h00;
      end
      drive(PATS[0], {56'hdead_beef_cafe_f0, 8'(m)}, 7'h30);
      check("R10 zap", res, exp_z);
      drive(PATS[0], {56'h1357_9bdf_0246_8a, 8'(m)}, 7'h31);
      check("R10 zapnot", res, exp_n);
    end
  endtask

  task automatic t_unknown;
    logic [6:0] bad [6] = '{7'h00, 7'h7f, 7'h10, 7'h03, 7'h38, 7'h5b};
    for (int i = 0; i < 6; i++) begin
      drive(64'hffff_ffff_ffff_ffff, 64'h5, bad[i]);
      check("R11 unlisted", res, 64'h0);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    a_in = '0; b_in = '0; f_in = '0;
    t_idle();
    t_shifts();
    t_field(0, "R4 mask-low", "R5 mask-high");
    t_field(1, "R6 ext-low", "R7 ext-high");
    t_field(2, "R8 ins-low", "R9 ins-high");
    t_offset_zero_edges();
    t_zap();
    t_unknown();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

endmodule